// File: doc/BRIEF.md
# Two's-Complement Adder-Subtractor with Dual Overflow Flags

This block is a purely combinational add/subtract unit of parameterised width (four bits unless overridden). One control input chooses between addition and subtraction. Subtraction reuses the adder: the second operand is inverted bit by bit and the chain's initial carry is forced high. The result has the operand width. Two overflow flags come out next to it. One is for callers that treat the operands as unsigned numbers, and the other is for callers that treat them as two's-complement numbers.

The datapath is a ripple of full-adder slices. An XOR stage on the second operand is steered by the operation select, and that same select drives the carry into the bottom slice. Signed overflow comes from comparing the carry that enters the most significant slice with the carry that leaves it. For subtraction, the unsigned flag is reported as a borrow, which is the complement of the chain's final carry. The block holds no state, so every output follows the present inputs.

Top module: `addsub_dualovf`

## Requirements
- R1: With `op_sub_i` = 0, `sum_o` equals (`opa_i` + `opb_i`) modulo 2^WIDTH.
- R2: With `op_sub_i` = 1, `sum_o` equals (`opa_i` − `opb_i`) modulo 2^WIDTH.
- R3: With `op_sub_i` = 0, `uovf_o` is 1 exactly when the unsigned sum exceeds 2^WIDTH − 1.
- R4: With `op_sub_i` = 1, `uovf_o` is 1 exactly when `opa_i` < `opb_i` as unsigned numbers (a borrow).
- R5: With `op_sub_i` = 0, `sovf_o` is 1 exactly when the signed sum lies outside −2^(WIDTH−1) … 2^(WIDTH−1) − 1.
- R6: With `op_sub_i` = 1, `sovf_o` is 1 exactly when the signed difference lies outside that same range.
- R7: At WIDTH = 4, adding 0100 and 0101 gives `sum_o` = 1001, `uovf_o` = 0 and `sovf_o` = 1.
- R8: At WIDTH = 4, adding 1100 and 1101 gives `sum_o` = 1001, `uovf_o` = 1 and `sovf_o` = 0.
- R9: Subtracting zero returns `opa_i` unchanged and both flags low, even though the internal chain carries out.
- R10: Subtracting the most negative value (1000 at WIDTH = 4) from zero gives 1000, with both flags high.
- R11: The outputs depend only on the present inputs. A new operand pair is reflected within the same cycle, and the previous operation leaves no trace.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sub_i | input | 1 | Operation select: 0 = add, 1 = subtract |
| opa_i | input | WIDTH | First operand (minuend when subtracting) |
| opb_i | input | WIDTH | Second operand (subtrahend when subtracting) |
| sum_o | output | WIDTH | Result, modulo 2^WIDTH |
| uovf_o | output | 1 | Unsigned overflow: carry out on add, borrow on subtract |
| sovf_o | output | 1 | Signed overflow |

## Verification
The bench sweeps every operand pair under both operations and compares the result against sums and differences taken at widened precision. This exposes a design that passes the raw carry through as the unsigned flag during subtraction: it would flag "no borrow" exactly when a borrow happened. The bench also probes subtraction of zero and of the most negative value. Those cases catch a flag taken from the wrong slice's carry, which would report signed overflow where none exists or miss it at the range edge. A missing forced carry-in would leave every difference off by one.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } addsub_op_e;

    typedef struct packed {
        logic unsigned_ovf;
        logic signed_ovf;
    } addsub_flags_t;

    // Flags from the two top carries of the chain.
    // carry_out: carry leaving the MSB slice; carry_msb: carry entering it.
    function automatic addsub_flags_t derive_flags(input addsub_op_e op,
                                                   input logic carry_out,
                                                   input logic carry_msb);
        addsub_flags_t f;
        f.unsigned_ovf = (op == OP_SUB) ? ~carry_out : carry_out;
        f.signed_ovf   = carry_out ^ carry_msb;
        return f;
    endfunction

endpackage

// File: rtl/addsub_fa_cell.sv
module addsub_fa_cell (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);
    logic half;

    always_comb begin
        half = a_i ^ b_i;
        s_o  = half ^ c_i;
        c_o  = (a_i & b_i) | (c_i & half);
    end
endmodule

// File: rtl/addsub_operand_cond.sv
module addsub_operand_cond #(
    parameter int WIDTH = 4
) (
    input  logic             invert_i,
    input  logic [WIDTH-1:0] opb_i,
    output logic [WIDTH-1:0] opb_cond_o
);
    for (genvar k = 0; k < WIDTH; k++) begin : g_xor
        assign opb_cond_o[k] = opb_i[k] ^ invert_i;
    end
endmodule

// File: rtl/addsub_ripple_chain.sv
module addsub_ripple_chain #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o,
    output logic             cmsb_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] carry;

    assign carry[0] = cin_i;

    for (genvar k = 0; k < WIDTH; k++) begin : g_slice
        addsub_fa_cell u_fa (
            .a_i (x_i[k]),
            .b_i (y_i[k]),
            .c_i (carry[k]),
            .s_o (sum_o[k]),
            .c_o (carry[k+1])
        );
    end

    assign cout_o = carry[WIDTH];
    assign cmsb_o = carry[MSB];
endmodule

// File: rtl/addsub_dualovf.sv
module addsub_dualovf
    import addsub_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             op_sub_i,
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             uovf_o,
    output logic             sovf_o
);
    addsub_op_e     op;
    logic [WIDTH-1:0] opb_cond;
    logic           chain_cout;
    logic           chain_cmsb;
    addsub_flags_t  flags;

    assign op = addsub_op_e'(op_sub_i);

    addsub_operand_cond #(.WIDTH(WIDTH)) u_cond (
        .invert_i   (op_sub_i),
        .opb_i      (opb_i),
        .opb_cond_o (opb_cond)
    );

    addsub_ripple_chain #(.WIDTH(WIDTH)) u_chain (
        .x_i    (opa_i),
        .y_i    (opb_cond),
        .cin_i  (op_sub_i),
        .sum_o  (sum_o),
        .cout_o (chain_cout),
        .cmsb_o (chain_cmsb)
    );

    always_comb begin
        flags  = derive_flags(op, chain_cout, chain_cmsb);
        uovf_o = flags.unsigned_ovf;
        sovf_o = flags.signed_ovf;
    end
endmodule

// File: rtl/addsub_dualovf_chk.sv
module addsub_dualovf_chk #(
    parameter int WIDTH = 4
) (
    input logic             op_sub_i,
    input logic [WIDTH-1:0] opa_i,
    input logic [WIDTH-1:0] opb_i,
    input logic [WIDTH-1:0] sum_o,
    input logic             uovf_o,
    input logic             sovf_o
);
    localparam int XW = WIDTH + 2;

    logic signed [XW-1:0] ua, ub, sa, sb, ures, sres;
    logic signed [XW-1:0] smax, smin;
    logic                 known;

    always_comb begin
        known = !$isunknown({op_sub_i, opa_i, opb_i});
        ua    = XW'({2'b00, opa_i});
        ub    = XW'({2'b00, opb_i});
        sa    = XW'(signed'({{2{opa_i[WIDTH-1]}}, opa_i}));
        sb    = XW'(signed'({{2{opb_i[WIDTH-1]}}, opb_i}));
        ures  = op_sub_i ? (ua - ub) : (ua + ub);
        sres  = op_sub_i ? (sa - sb) : (sa + sb);
        smax  = XW'((1 << (WIDTH - 1)) - 1);
        smin  = -XW'(1 << (WIDTH - 1));
        if (known) begin
            // R1 R2: result modulo 2^WIDTH
            a_r1_r2_result: assert final (sum_o == ures[WIDTH-1:0]);
            // R3: add overflow when the widened sum reaches 2^WIDTH
            if (!op_sub_i) begin
                a_r3_add_carry: assert final (uovf_o == (ures > XW'((1 << WIDTH) - 1)));
                a_r5_add_signed: assert final (sovf_o == (sres > smax || sres < smin));
            end else begin
                a_r4_sub_borrow: assert final (uovf_o == (ures < 0));
                a_r6_sub_signed: assert final (sovf_o == (sres > smax || sres < smin));
            end
        end
    end
endmodule

bind addsub_dualovf addsub_dualovf_chk #(.WIDTH(WIDTH)) u_addsub_chk (
    .op_sub_i (op_sub_i),
    .opa_i    (opa_i),
    .opb_i    (opb_i),
    .sum_o    (sum_o),
    .uovf_o   (uovf_o),
    .sovf_o   (sovf_o)
);

// File: tb/test_addsub_dualovf.sv
module test_addsub_dualovf;
    localparam int W  = 4;
    localparam int N  = 1 << W;
    localparam int SMAX = (1 << (W - 1)) - 1;
    localparam int SMIN = -(1 << (W - 1));

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         op_sub;
    logic [W-1:0] opa, opb;
    logic [W-1:0] sum;
    logic         uovf, sovf;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;  // 50 MHz

    addsub_dualovf #(.WIDTH(W)) i_addsub_dualovf (
        .op_sub_i (op_sub),
        .opa_i    (opa),
        .opb_i    (opb),
        .sum_o    (sum),
        .uovf_o   (uovf),
        .sovf_o   (sovf)
    );

    task automatic check(input string req, input int got, input int exp);
        n_vec++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: op=%0d a=%0h b=%0h got=%0h expected=%0h",
                     req, op_sub, opa, opb, got, exp);
        end
    endtask

    // Drive on the falling edge, sample one time unit after the rising edge.
    task automatic apply(input logic s, input int a, input int b);
        @(negedge clk);
        op_sub = s;
        opa    = W'(a);
        opb    = W'(b);
        @(posedge clk);
        #1;
    endtask

    function automatic int sx(input int v);
        return (v >= N / 2) ? v - N : v;
    endfunction

    task automatic t_reset_state();
        apply(1'b0, 0, 0);
        check("R1 reset sum", int'(sum), 0);
        check("R3 reset uovf", int'(uovf), 0);
        check("R5 reset sovf", int'(sovf), 0);
    endtask

    task automatic t_sweep();
        for (int s = 0; s < 2; s++) begin
            for (int a = 0; a < N; a++) begin
                for (int b = 0; b < N; b++) begin
                    int u, sg;
                    apply(s[0], a, b);
                    u  = s ? a - b : a + b;
                    sg = s ? sx(a) - sx(b) : sx(a) + sx(b);
                    if (s == 0) begin
                        check("R1 sum", int'(sum), u & (N - 1));
                        check("R3 uovf", int'(uovf), int'(u > N - 1));
                        check("R5 sovf", int'(sovf), int'(sg > SMAX || sg < SMIN));
                    end else begin
                        check("R2 diff", int'(sum), u & (N - 1));
                        check("R4 borrow", int'(uovf), int'(a < b));
                        check("R6 sovf", int'(sovf), int'(sg > SMAX || sg < SMIN));
                    end
                end
            end
        end
    endtask

    task automatic t_examples();
        apply(1'b0, 4'b0100, 4'b0101);
        check("R7 sum", int'(sum), 4'b1001);
        check("R7 uovf", int'(uovf), 0);
        check("R7 sovf", int'(sovf), 1);
        apply(1'b0, 4'b1100, 4'b1101);
        check("R8 sum", int'(sum), 4'b1001);
        check("R8 uovf", int'(uovf), 1);
        check("R8 sovf", int'(sovf), 0);
    endtask

    task automatic t_edges();
        apply(1'b1, 4'b1011, 0);
        check("R9 sum", int'(sum), 4'b1011);
        check("R9 uovf", int'(uovf), 0);
        check("R9 sovf", int'(sovf), 0);
        apply(1'b1, 0, 4'b1000);
        check("R10 sum", int'(sum), 4'b1000);
        check("R10 uovf", int'(uovf), 1);
        check("R10 sovf", int'(sovf), 1);
    endtask

    task automatic t_no_memory();
        // R11: same operands after a different operation give the fresh answer
        apply(1'b1, 4'b0011, 4'b0101);
        check("R11 prior diff", int'(sum), 4'b1110);
        apply(1'b0, 4'b0011, 4'b0101);
        check("R11 sum", int'(sum), 4'b1000);
        check("R11 uovf", int'(uovf), 0);
        check("R11 sovf", int'(sovf), 1);
    endtask

    initial begin
        op_sub = 1'b0;
        opa    = '0;
        opb    = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_reset_state();
        t_examples();
        t_edges();
        t_no_memory();
        t_sweep();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule